// File: doc/BRIEF.md
# Lockable Block-Map Configuration Registers

This block is the software-facing register bank for a memory security filter. Memory is split into fixed-size blocks. Each block has one bit in a lookup table of 32-bit words: 0 marks the block secure and 1 marks it non-secure. Software reaches a table word through an index register and a data window. With the auto-advance option, successive word accesses walk the table. The bank also holds a control word, the interrupt status and enable, two registers that record the first blocked access, and a read-only identification area.

The companion transaction filter reads the table words, the control bits and the interrupt enable from this block. When the filter blocks an access, it reports that access through a one-cycle fault-capture strobe. A sticky lockdown bit freezes the control word, the table window and the interrupt enable until the next reset. Non-secure masters can see only the identification area.

Register accesses complete in one cycle. Read data is combinational from the address. Every side effect of an access takes place at the clock edge on which `reg_en` is high.

Top module: `blkmap_cfg`

## Requirements
- R1: After reset, the registers read as follows. The control word (0x00) is 0x00000100, the index (0x18) is 0, the status (0x20) is 0, the enable (0x28) is 1, and both info registers (0x2C, 0x30) are 0. Every table word is 0 and `irq` is low.
- R2: A write to the control word keeps only three bits: bit 4 is the error-response enable, bit 8 is index auto-advance and bit 31 is lockdown. All other control bits read as 0.
- R3: When `reg_secure` is low, an access to any offset below 0xFD0 reads 0 and its write has no effect. The identification area stays readable.
- R4: While lockdown is set, writes to the control word, the table window (0x1C) and the enable register are ignored. Index, set and clear writes still act. Only reset clears lockdown.
- R5: With auto-advance set, a word-size read or write of the table window moves the index up by one and wraps from LUT_WORDS-1 to 0. Byte and halfword accesses never move the index, and neither does a write that lockdown blocks.
- R6: A write to the index register stores the value modulo LUT_WORDS. Offset 0x10 reads LUT_WORDS-1. Offset 0x14 reads log2(BLOCK_BYTES)-5.
- R7: `reg_size` selects the access width: 0 is a byte, 1 is a halfword and 2 or 3 is a word. Write data sits in the low lanes and goes to byte lane `reg_addr[1:0]`. A sub-word write to the control word, the index or the table window merges into the current value. A sub-word write to any other register fills the untouched lanes with zeros.
- R8: A sub-word read returns the addressed lanes of the word, shifted down to bit 0.
- R9: Writing bit 0 = 1 to offset 0x34 sets the status. Writing bit 0 = 1 to offset 0x24 clears it. Both offsets read 0. `irq` is the status AND the enable.
- R10: The word offsets from 0xFD0 to 0xFFC read, in order, 0x04, 0x00, 0x00, 0x00, 0x60, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05 and 0xB1. Writes to them are ignored.
- R11: A `flt_valid` pulse while the status is 0 sets the status and records the access. Info1 takes `flt_addr`. Info2 takes the master in bits 15:0, `flt_nonsec` in bit 16 and `flt_cfg_ns` in bit 17. While the status is 1, fault pulses change nothing.
- R12: Undefined offsets read 0 and ignore writes.
- R13: Table word k appears on `lut_flat[32k+31:32k]`. `sec_resp_en`, `lockdown` and `int_en` follow control bits 4 and 31 and the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset |
| reg_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| reg_wdata | input | 32 | Write data, low-lane aligned |
| reg_secure | input | 1 | Access is secure |
| reg_rdata | output | 32 | Read data |
| lut_flat | output | 32*LUT_WORDS | All table words |
| sec_resp_en | output | 1 | Blocked accesses return an error |
| lockdown | output | 1 | Lockdown active |
| int_en | output | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| flt_valid | input | 1 | Fault-capture strobe from the filter |
| flt_addr | input | 32 | Address of the blocked access |
| flt_master | input | 16 | Requester ID of the blocked access |
| flt_nonsec | input | 1 | Blocked access was non-secure |
| flt_cfg_ns | input | 1 | Table bit of the blocked block |

## Verification
The bench builds the block with LUT_WORDS=3 and BLOCK_BYTES=256. A depth that is not a power of two makes the modulo on index writes and the auto-advance wrap differ from a plain bit truncation. The size field then reads 3. With only three table words, the bench can sweep every index value from 0 to 7, walk the table past its end in both directions, and read every identification word.

// File: rtl/blkmap_cfg.sv
module blkmap_cfg #(
  parameter int BLOCK_BYTES = 256,
  parameter int LUT_WORDS   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_en,
  input  logic                    reg_wr,
  input  logic [11:0]             reg_addr,
  input  logic [1:0]              reg_size,
  input  logic [31:0]             reg_wdata,
  input  logic                    reg_secure,
  output logic [31:0]             reg_rdata,
  output logic [32*LUT_WORDS-1:0] lut_flat,
  output logic                    sec_resp_en,
  output logic                    lockdown,
  output logic                    int_en,
  output logic                    irq,
  input  logic                    flt_valid,
  input  logic [31:0]             flt_addr,
  input  logic [15:0]             flt_master,
  input  logic                    flt_nonsec,
  input  logic                    flt_cfg_ns
);
  localparam int IW   = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1;
  localparam int CFGV = $clog2(BLOCK_BYTES) - 5;

  logic          resp_q, ainc_q, lock_q, en_q, stat_q;
  logic [IW-1:0] idx_q;
  logic [31:0]   info1_q, info2_q;
  logic [31:0]   lut [LUT_WORDS];

  logic [9:0]  waddr;
  logic        is_word, allowed, wr_ok, lut_step;
  logic [4:0]  sh;
  logic [31:0] lane_mask, ctrl_word, rword, old_val, merged;
  logic [IW-1:0] idx_inc;

  assign waddr     = reg_addr[11:2];
  assign is_word   = reg_size[1];
  assign sh        = {reg_addr[1:0], 3'b000};
  assign allowed   = reg_secure || (waddr >= 10'h3F4);
  assign wr_ok     = reg_en && reg_wr && allowed;
  assign ctrl_word = {lock_q, 22'd0, ainc_q, 3'd0, resp_q, 4'd0};
  assign lane_mask = is_word ? 32'hFFFF_FFFF :
                     ((reg_size[0] ? 32'h0000_FFFF : 32'h0000_00FF) << sh);

  always_comb begin
    case (waddr)
      10'h000: rword = ctrl_word;
      10'h004: rword = 32'(LUT_WORDS - 1);
      10'h005: rword = 32'(CFGV);
      10'h006: rword = 32'(idx_q);
      10'h007: rword = lut[idx_q];
      10'h008: rword = {31'd0, stat_q};
      10'h00A: rword = {31'd0, en_q};
      10'h00B: rword = info1_q;
      10'h00C: rword = info2_q;
      10'h3F4: rword = 32'h04;
      10'h3F8: rword = 32'h60;
      10'h3F9: rword = 32'hB8;
      10'h3FA: rword = 32'h1B;
      10'h3FC: rword = 32'h0D;
      10'h3FD: rword = 32'hF0;
      10'h3FE: rword = 32'h05;
      10'h3FF: rword = 32'hB1;
      default: rword = 32'd0;
    endcase
    case (waddr)
      10'h000: old_val = ctrl_word;
      10'h006: old_val = 32'(idx_q);
      10'h007: old_val = lut[idx_q];
      default: old_val = 32'd0;
    endcase
  end

  assign merged    = (old_val & ~lane_mask) | ((reg_wdata << sh) & lane_mask);
  assign reg_rdata = !allowed ? 32'd0 :
                     is_word  ? rword :
                     ((rword >> sh) & (reg_size[0] ? 32'h0000_FFFF : 32'h0000_00FF));

  assign lut_step = reg_en && allowed && (waddr == 10'h007) && is_word && ainc_q &&
                    (!reg_wr || !lock_q);
  assign idx_inc  = (idx_q == IW'(LUT_WORDS - 1)) ? '0 : IW'(idx_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q  <= 1'b0;
      ainc_q  <= 1'b1;
      lock_q  <= 1'b0;
      en_q    <= 1'b1;
      stat_q  <= 1'b0;
      idx_q   <= '0;
      info1_q <= '0;
      info2_q <= '0;
      for (int k = 0; k < LUT_WORDS; k++) lut[k] <= '0;
    end else begin
      if (wr_ok && waddr == 10'h000 && !lock_q) begin
        resp_q <= merged[4];
        ainc_q <= merged[8];
        lock_q <= merged[31];
      end
      if (wr_ok && waddr == 10'h006) idx_q <= IW'(merged % 32'(LUT_WORDS));
      else if (lut_step)             idx_q <= idx_inc;
      if (wr_ok && waddr == 10'h007 && !lock_q) lut[idx_q] <= merged;
      if (wr_ok && waddr == 10'h00A && !lock_q) en_q <= merged[0];
      if (wr_ok && waddr == 10'h009 && merged[0]) stat_q <= 1'b0;
      if (wr_ok && waddr == 10'h00D && merged[0]) stat_q <= 1'b1;
      if (flt_valid && !stat_q) begin
        stat_q  <= 1'b1;
        info1_q <= flt_addr;
        info2_q <= {14'd0, flt_cfg_ns, flt_nonsec, flt_master};
      end
    end
  end

  for (genvar k = 0; k < LUT_WORDS; k++) begin : g_out
    assign lut_flat[32*k +: 32] = lut[k];
  end

  assign sec_resp_en = resp_q;
  assign lockdown    = lock_q;
  assign int_en      = en_q;
  assign irq         = stat_q && en_q;

  assert_idx_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < LUT_WORDS);
  assert_ns_write_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_wr && !reg_secure && reg_addr < 12'hFD0)
      |=> ($stable(ctrl_word) && $stable(idx_q) && $stable(en_q)));
  assert_lock_freezes_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |=> ($stable(ctrl_word) && $stable(int_en)));
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |=> lockdown);
  assert_capture_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q |=> ($stable(info1_q) && $stable(info2_q)));
endmodule

// File: tb/blkmap_cfg_bench.sv
module blkmap_cfg_bench;
  localparam int LW = 3;
  localparam int BB = 256;

  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_wr = 0, reg_secure = 1;
  logic [11:0] reg_addr = 0;
  logic [1:0]  reg_size = 2;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [32*LW-1:0] lut_flat;
  logic sec_resp_en, lockdown, int_en, irq;
  logic flt_valid = 0, flt_nonsec = 0, flt_cfg_ns = 0;
  logic [31:0] flt_addr = 0;
  logic [15:0] flt_master = 0;
  logic [31:0] rd;
  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] pat [LW];

  blkmap_cfg #(.BLOCK_BYTES(BB), .LUT_WORDS(LW)) u_blkmap_cfg (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic sec);
    @(negedge clk);
    reg_en = 1; reg_wr = wr; reg_addr = a; reg_size = sz; reg_wdata = d; reg_secure = sec;
    #2 rd = reg_rdata;
    @(posedge clk);
    #1 reg_en = 0; reg_wr = 0; reg_secure = 1;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d); acc(1, a, 2, d, 1); endtask
  task automatic rd32(input logic [11:0] a); acc(0, a, 2, 0, 1); endtask

  task automatic fault(input logic [31:0] a, input logic [15:0] m, input logic ns, input logic cn);
    @(negedge clk);
    flt_valid = 1; flt_addr = a; flt_master = m; flt_nonsec = ns; flt_cfg_ns = cn;
    @(posedge clk);
    #1 flt_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] idv [12];
    int ex;
    idv = '{32'h04, 32'h00, 32'h00, 32'h00, 32'h60, 32'hB8, 32'h1B, 32'h00,
            32'h0D, 32'hF0, 32'h05, 32'hB1};
    repeat (2) @(negedge clk);
    rst_n = 1;

    rd32(12'h000); check("R1 ctrl", rd, 32'h100);
    rd32(12'h018); check("R1 idx", rd, 0);
    rd32(12'h020); check("R1 stat", rd, 0);
    rd32(12'h028); check("R1 en", rd, 1);
    rd32(12'h02C); check("R1 info1", rd, 0);
    rd32(12'h030); check("R1 info2", rd, 0);
    check("R1 lut", lut_flat, 0);
    check("R1 irq", irq, 0);

    rd32(12'h010); check("R6 max", rd, LW - 1);
    rd32(12'h014); check("R6 cfg", rd, 3);
    for (int v = 0; v < 8; v++) begin
      wr32(12'h018, v); rd32(12'h018); check("R6 idx mod", rd, v % LW);
    end

    wr32(12'h018, 0);
    for (int k = 0; k < 4; k++) begin
      wr32(12'h01C, 32'hA5000000 + k);
      if (k < LW) pat[k] = 32'hA5000000 + k; else pat[k % LW] = 32'hA5000000 + k;
      rd32(12'h018); check("R5 wr advance", rd, (k + 1) % LW);
    end
    for (int k = 0; k < LW; k++) check("R13 lut word", lut_flat[32*k +: 32], pat[k]);
    wr32(12'h018, 0);
    for (int k = 0; k < 4; k++) begin
      rd32(12'h01C); check("R5 rd data", rd, pat[k % LW]);
      rd32(12'h018); check("R5 rd advance", rd, (k + 1) % LW);
    end

    wr32(12'h018, 1);
    acc(1, 12'h01E, 0, 32'h000000CC, 1);
    rd32(12'h018); check("R5 byte no advance", rd, 1);
    pat[1] = {pat[1][31:24], 8'hCC, pat[1][15:0]};
    check("R7 lut merge", lut_flat[63:32], pat[1]);
    acc(0, 12'h01F, 0, 0, 1); check("R8 byte read", rd, {24'd0, pat[1][31:24]});
    acc(0, 12'h01E, 1, 0, 1); check("R8 half read", rd, {16'd0, pat[1][31:16]});
    rd32(12'h018); check("R5 sub read no advance", rd, 1);
    acc(0, 12'h001, 0, 0, 1); check("R8 ctrl byte", rd, 32'h01);

    wr32(12'h000, 32'h7FFFFFFF); rd32(12'h000); check("R2 ctrl mask", rd, 32'h110);
    check("R13 resp out", sec_resp_en, 1);
    acc(1, 12'h001, 0, 32'h00, 1); rd32(12'h000); check("R7 ctrl merge", rd, 32'h10);
    wr32(12'h018, 0); wr32(12'h01C, 32'h11); rd32(12'h018); check("R5 ainc off", rd, 0);
    wr32(12'h000, 32'h100);

    acc(1, 12'h029, 0, 32'hFF, 1); rd32(12'h028); check("R7 zero fill", rd, 0);
    check("R13 en out", int_en, 0);
    wr32(12'h034, 1); rd32(12'h020); check("R9 set", rd, 1);
    check("R9 irq masked", irq, 0);
    wr32(12'h028, 1); check("R9 irq on", irq, 1);
    rd32(12'h034); check("R9 set reads 0", rd, 0);
    rd32(12'h024); check("R9 clr reads 0", rd, 0);
    wr32(12'h024, 1); rd32(12'h020); check("R9 clear", rd, 0);
    check("R9 irq off", irq, 0);

    fault(32'h0000_1240, 16'h1234, 1, 0);
    rd32(12'h020); check("R11 stat", rd, 1);
    rd32(12'h02C); check("R11 info1", rd, 32'h1240);
    rd32(12'h030); check("R11 info2", rd, 32'h0001_1234);
    fault(32'h0000_9999, 16'hBEEF, 0, 1);
    rd32(12'h02C); check("R11 hold info1", rd, 32'h1240);
    rd32(12'h030); check("R11 hold info2", rd, 32'h0001_1234);
    wr32(12'h024, 1);
    fault(32'h0000_9999, 16'hBEEF, 0, 1);
    rd32(12'h030); check("R11 recapture", rd, 32'h0002_BEEF);
    wr32(12'h024, 1);

    acc(0, 12'h000, 2, 0, 0); check("R3 ns read", rd, 0);
    acc(1, 12'h000, 2, 32'h80000000, 0); rd32(12'h000); check("R3 ns write", rd, 32'h100);
    acc(1, 12'h018, 2, 2, 0); rd32(12'h018); check("R3 ns idx", rd, 0);
    acc(0, 12'hFE0, 2, 0, 0); check("R3 ns id", rd, 32'h60);

    for (int k = 0; k < 12; k++) begin
      rd32(12'hFD0 + 12'(4 * k)); check("R10 id", rd, idv[k]);
    end
    wr32(12'hFFC, 32'h12345678); rd32(12'hFFC); check("R10 id ro", rd, 32'hB1);
    rd32(12'h040); check("R12 undef", rd, 0);
    wr32(12'hFCC, 32'hFFFF); rd32(12'hFCC); check("R12 undef wr", rd, 0);

    wr32(12'h018, 2); ex = lut_flat[95:64];
    wr32(12'h000, 32'h80000110);
    check("R13 lock out", lockdown, 1);
    wr32(12'h000, 0); rd32(12'h000); check("R4 ctrl frozen", rd, 32'h80000110);
    wr32(12'h01C, 32'hDEAD); check("R4 lut frozen", lut_flat[95:64], ex);
    rd32(12'h018); check("R5 blocked no advance", rd, 2);
    wr32(12'h028, 0); rd32(12'h028); check("R4 en frozen", rd, 1);
    wr32(12'h018, 1); rd32(12'h018); check("R4 idx live", rd, 1);
    wr32(12'h034, 1); check("R4 set live", irq, 1);
    do_reset();
    rd32(12'h000); check("R4 reset unlocks", rd, 32'h100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule